// File: doc/BRIEF.md
# I2C Slave Status and Own-Address Tracker

This block sits beside the bit-level engine of an I2C controller that can act either as master or as slave. It takes the already-decoded bus events and keeps a small set of status flags for that controller. The events are START and STOP strobes, an address-byte-complete strobe that comes with the received 8-bit address byte, and an acknowledge strobe that comes with the sampled acknowledge bit. The block also holds the controller's programmable 7-bit own address. It raises a one-cycle match pulse when a received address selects this unit as slave.

Software reaches the block through a plain read port that has two views: the status word and the own-address register. The own-address register has its own power-on reset, so a processor reset (`rst_ni`) leaves it unchanged. The processor reset clears only the bus status flags.

Top module: `i2c_stat_track`

## Requirements
- R1: The own-address register is 7 bits wide and reads as 0 after power-on reset (`por_ni` low). With `rd_sel_i`=1 the read port returns the register in bits 6:0, and bits 31:7 read as 0.
- R2: Asserting the processor reset `rst_ni` does not change the own-address register.
- R3: When unit-busy is 0, a write (`addr_we_i`=1) loads `addr_wdata_i`, and the new value is readable in the cycle after the write edge.
- R4: When unit-busy is 1, writes to the own-address register are ignored and the register keeps its old value.
- R5: `match_o` is 1 in the same cycle as `addr_done_i` when `addr_byte_i[7:1]` equals the own address and `is_master_i` is 0.
- R6: `match_o` is 0 whenever `is_master_i` is 1, whenever the address bits differ from the own address, and whenever `addr_done_i` is 0.
- R7: Unit-busy becomes 1 on the edge that samples `start_i` and becomes 0 on the edge that samples `stop_i`. A repeated START while busy leaves it at 1.
- R8: On each `ack_valid_i` the ACK/NAK flag takes `ack_bit_i` (0 = ACK, 1 = NAK). Between acknowledge strobes the flag holds its value.
- R9: On each `addr_done_i` the read/write-mode flag takes `addr_byte_i[0]` (0 = master-transmit/slave-receive, 1 = master-receive/slave-transmit). This includes the address byte that follows a repeated START.
- R10: `stop_i` clears the read/write-mode flag. A STOP sampled on the same edge as `addr_done_i` wins, so the flag ends at 0.
- R11: With `rd_sel_i`=0 the read port returns the status word: bit 0 is read/write-mode, bit 1 is ACK/NAK, bit 2 is unit-busy, and bits 31:3 are 0.
- R12: `rst_ni` low clears unit-busy, ACK/NAK and read/write-mode asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Processor reset, active low, asynchronous; clears the status flags |
| por_ni | input | 1 | Power-on reset, active low, asynchronous; clears the own-address register |
| start_i | input | 1 | START or repeated START detected |
| stop_i | input | 1 | STOP detected |
| addr_done_i | input | 1 | Address byte complete |
| addr_byte_i | input | 8 | Received address byte: 7-bit address in bits 7:1, R/nW in bit 0 |
| ack_valid_i | input | 1 | Acknowledge bit sampled |
| ack_bit_i | input | 1 | Sampled acknowledge bit, 0 = ACK, 1 = NAK |
| is_master_i | input | 1 | Controller is currently acting as bus master |
| addr_we_i | input | 1 | Own-address write enable |
| addr_wdata_i | input | 7 | Own-address write data |
| rd_sel_i | input | 1 | Read view select: 0 = status word, 1 = own address |
| rd_data_o | output | 32 | Read data |
| match_o | output | 1 | Slave address match pulse |

## Verification
`match_o` and `rd_data_o` are combinational. The bench therefore checks the match pulse 1 ns after it drives the address strobe, before the next rising edge. Every flag and the own-address register are updated by one register stage. Each stimulus is applied at a falling edge, is sampled on the following rising edge, and its result is read at the falling edge after that, one cycle after the stimulus. The match sweep covers all 256 address bytes, with and without master mode, for four own-address values. It compares each result against the address bits computed arithmetically in the bench.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  parameter int unsigned ADDR_W = 7;
  parameter int unsigned BYTE_W = ADDR_W + 1;
  parameter int unsigned DATA_W = 32;

  typedef struct packed {
    logic busy;
    logic ack_nak;
    logic rw;
  } stat_t;

  localparam int unsigned STAT_W = $bits(stat_t);
endpackage

// File: rtl/own_addr_reg.sv
module own_addr_reg #(
  parameter int unsigned AW = 7
) (
  input  logic          clk_i,
  input  logic          por_ni,
  input  logic          we_i,
  input  logic          lock_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] addr_o
);
  // power-on reset only: survives processor reset
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)              addr_o <= '0;
    else if (we_i && !lock_i) addr_o <= wdata_i;
  end

  AST_WR_TAKEN: assert property (@(posedge clk_i) disable iff (!por_ni)
    (we_i && !lock_i) |=> addr_o == $past(wdata_i)); // R3
  AST_WR_LOCKED: assert property (@(posedge clk_i) disable iff (!por_ni)
    (we_i && lock_i) |=> $stable(addr_o)); // R4
endmodule

// File: rtl/bus_status.sv
module bus_status
  import i2c_stat_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  stop_i,
  input  logic  addr_done_i,
  input  logic  rw_bit_i,
  input  logic  ack_valid_i,
  input  logic  ack_bit_i,
  output stat_t stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
    end else begin
      if (stop_i)       stat_o.busy <= 1'b0;
      else if (start_i) stat_o.busy <= 1'b1;
      // STOP wins over a coincident address byte
      if (stop_i)           stat_o.rw <= 1'b0;
      else if (addr_done_i) stat_o.rw <= rw_bit_i;
      if (ack_valid_i) stat_o.ack_nak <= ack_bit_i;
    end
  end

  AST_BUSY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> stat_o.busy); // R7
  AST_BUSY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !stat_o.busy); // R7
  AST_RW_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !stat_o.rw); // R10
  AST_RW_CAPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_done_i && !stop_i) |=> stat_o.rw == $past(rw_bit_i)); // R9
  AST_ACK_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_i |=> stat_o.ack_nak == $past(ack_bit_i)); // R8
  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_valid_i |=> $stable(stat_o.ack_nak)); // R8
endmodule

// File: rtl/addr_match.sv
module addr_match #(
  parameter int unsigned AW = 7
) (
  input  logic          done_i,
  input  logic          master_i,
  input  logic [AW:0]   byte_i,
  input  logic [AW-1:0] own_i,
  output logic          match_o
);
  logic [AW-1:0] bit_eq;

  for (genvar i = 0; i < AW; i++) begin : g_cmp
    assign bit_eq[i] = ~(byte_i[i+1] ^ own_i[i]);
  end

  assign match_o = done_i & ~master_i & (&bit_eq);
endmodule

// File: rtl/i2c_stat_track.sv
module i2c_stat_track
  import i2c_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_done_i,
  input  logic [BYTE_W-1:0] addr_byte_i,
  input  logic              ack_valid_i,
  input  logic              ack_bit_i,
  input  logic              is_master_i,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              match_o
);
  localparam int unsigned ADDR_PAD = DATA_W - ADDR_W;
  localparam int unsigned STAT_PAD = DATA_W - STAT_W;

  logic [ADDR_W-1:0] own_addr;
  stat_t             stat;

  own_addr_reg #(.AW(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .por_ni  (por_ni),
    .we_i    (addr_we_i),
    .lock_i  (stat.busy),
    .wdata_i (addr_wdata_i),
    .addr_o  (own_addr)
  );

  bus_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .addr_done_i (addr_done_i),
    .rw_bit_i    (addr_byte_i[0]),
    .ack_valid_i (ack_valid_i),
    .ack_bit_i   (ack_bit_i),
    .stat_o      (stat)
  );

  addr_match #(.AW(ADDR_W)) u_match (
    .done_i   (addr_done_i),
    .master_i (is_master_i),
    .byte_i   (addr_byte_i),
    .own_i    (own_addr),
    .match_o  (match_o)
  );

  always_comb begin
    if (rd_sel_i) rd_data_o = {{ADDR_PAD{1'b0}}, own_addr};
    else          rd_data_o = {{STAT_PAD{1'b0}}, stat.busy, stat.ack_nak, stat.rw};
  end

  AST_MATCH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    match_o |-> (addr_done_i && !is_master_i)); // R6
  AST_MATCH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    match_o |-> addr_byte_i[BYTE_W-1:1] == own_addr); // R5
endmodule

// File: tb/tb_i2c_stat_track.sv
module tb_i2c_stat_track;
  localparam time PER = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni, por_ni;
  logic        start_i, stop_i, addr_done_i, ack_valid_i, ack_bit_i, is_master_i;
  logic [7:0]  addr_byte_i;
  logic        addr_we_i, rd_sel_i;
  logic [6:0]  addr_wdata_i;
  logic [31:0] rd_data_o;
  logic        match_o;

  int total = 0;
  int bad   = 0;

  always #(PER/2) clk_i = ~clk_i;

  i2c_stat_track dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic sel, input logic [31:0] exp, input string req);
    rd_sel_i = sel;
    #1;
    chk(rd_data_o === exp, req, rd_data_o, exp);
  endtask

  task automatic nedge();
    @(negedge clk_i);
    start_i = 0; stop_i = 0; addr_done_i = 0; ack_valid_i = 0; addr_we_i = 0;
  endtask

  task automatic wr_addr(input logic [6:0] a);
    @(negedge clk_i);
    addr_we_i = 1; addr_wdata_i = a;
    nedge();
  endtask

  initial begin
    #(PER*200000);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 0; por_ni = 0;
    start_i = 0; stop_i = 0; addr_done_i = 0; ack_valid_i = 0; ack_bit_i = 0;
    is_master_i = 0; addr_byte_i = '0; addr_we_i = 0; addr_wdata_i = '0; rd_sel_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1; por_ni = 1;
    rd_chk(1, 32'h0, "R1 por addr");
    rd_chk(0, 32'h0, "R12 reset status");

    // R3 / R1: every address value, upper bits zero
    for (int a = 0; a < 128; a++) begin
      wr_addr(7'(a));
      rd_chk(1, 32'(a), "R3 write readback");
    end

    wr_addr(7'h2A);
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
    rd_chk(1, 32'h2A, "R2 addr kept over rst_ni");

    @(negedge clk_i); start_i = 1;
    nedge();
    rd_chk(0, 32'h4, "R7 busy on start");
    wr_addr(7'h11);
    rd_chk(1, 32'h2A, "R4 write ignored busy");

    @(negedge clk_i); addr_done_i = 1; addr_byte_i = {7'h2A, 1'b1};
    #1 chk(match_o === 1'b1, "R5 match", 32'(match_o), 32'h1);
    nedge();
    #1 chk(match_o === 1'b0, "R6 no match idle", 32'(match_o), 32'h0);
    rd_chk(0, 32'h5, "R9 rw captured");

    @(negedge clk_i); ack_valid_i = 1; ack_bit_i = 1;
    nedge();
    rd_chk(0, 32'h7, "R8 nak");
    ack_bit_i = 0;
    nedge();
    rd_chk(0, 32'h7, "R8 hold");
    @(negedge clk_i); ack_valid_i = 1; ack_bit_i = 0;
    nedge();
    rd_chk(0, 32'h5, "R8 ack");

    @(negedge clk_i); start_i = 1;
    nedge();
    rd_chk(0, 32'h5, "R7 repeated start");
    @(negedge clk_i); addr_done_i = 1; addr_byte_i = {7'h2A, 1'b0};
    nedge();
    rd_chk(0, 32'h4, "R9 recapture");

    @(negedge clk_i); ack_valid_i = 1; ack_bit_i = 1;
    nedge();
    @(negedge clk_i); stop_i = 1; addr_done_i = 1; addr_byte_i = 8'h55;
    nedge();
    rd_chk(0, 32'h2, "R10 stop wins, R11 layout");
    wr_addr(7'h33);
    rd_chk(1, 32'h33, "R3 write after stop");

    // R5 / R6 sweep
    for (int k = 0; k < 4; k++) begin
      logic [6:0] own;
      own = (k == 0) ? 7'h00 : (k == 1) ? 7'h2A : (k == 2) ? 7'h55 : 7'h7F;
      wr_addr(own);
      for (int b = 0; b < 256; b++) begin
        for (int m = 0; m < 2; m++) begin
          logic exp;
          @(negedge clk_i);
          addr_done_i = 1; addr_byte_i = 8'(b); is_master_i = 1'(m);
          exp = (m == 0) && ((b >> 1) == int'(own));
          #1 chk(match_o === exp, exp ? "R5 sweep" : "R6 sweep", 32'(match_o), 32'(exp));
        end
      end
      nedge();
      is_master_i = 0;
    end

    @(negedge clk_i); start_i = 1; ack_valid_i = 1; ack_bit_i = 1; addr_done_i = 1; addr_byte_i = 8'h01;
    nedge();
    rd_chk(0, 32'h7, "R11 all set");
    @(negedge clk_i); rst_ni = 0;
    #1 rd_chk(0, 32'h0, "R12 async clear");
    @(negedge clk_i); rst_ni = 1;
    rd_chk(1, 32'h7F, "R2 addr kept");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule